// File: doc/BRIEF.md
# Page Write Engine with Timed Commit

This block sits behind a two-wire serial front end in a small 128-by-8 byte store. The front end decodes the bus and hands over one-cycle event pulses: a word address was received, a data byte was acknowledged, a start was seen, a stop was seen, or an address byte wants an acknowledge decision. The engine keeps the incoming data bytes in a four-byte page buffer. The high five bits of the word address pick the page. The low two bits pick the starting slot, and this slot pointer wraps inside the page.

When a stop closes a transaction that carried at least one data byte, the engine runs a self-timed commit. It copies the slots that were filled into the array, one beat per cycle, and holds `busy` high for a fixed, parameterised number of system clocks. This window stands in for the multi-millisecond programming time of a real cell array. While `busy` is high, every bus event is ignored and acknowledge requests are refused, so a master can poll until an acknowledge comes back. A one-cycle `done` pulse marks the end of the window. A synchronous read port gives access to the array contents.

Top module: `page_commit_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `poll_ack` and `mem_we` are all low.
- R2: An `addr_load` pulse takes bits 6..2 of `addr_in` as the page and bits 1..0 as the starting slot. Every commit write lands in that page (`mem_addr[6:2]` equals the loaded page).
- R3: Each `data_load` pulse stores `data_in` in the current slot and then advances the slot by one, modulo 4. The page bits never change. After the fourth slot the pointer returns to the page's first slot, so a fifth or sixth byte overwrites a byte buffered earlier in the same transaction.
- R4: A commit writes only the slots that received a byte in the transaction. The other bytes of the page and all other pages keep their previous contents.
- R5: A `stop_evt` with at least one buffered byte raises `busy` in the next cycle. `busy` then stays high for exactly `WR_CYCLES` consecutive cycles.
- R6: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a commit window.
- R7: `mem_we` is high only while `busy` is high, and exactly once per filled slot in each commit.
- R8: `poll_ack` is high in the cycle after a `poll_req` exactly when `busy` was low at the request. A request during the commit window gets no acknowledge.
- R9: While `busy` is high, `addr_load`, `data_load`, `start_evt`, `stop_evt` and their data are ignored. They change neither the committed result nor the following array contents.
- R10: A `stop_evt` with no buffered byte starts no commit. A `start_evt` or a new `addr_load` discards all bytes buffered so far.
- R11: `rd_data` shows the array byte at `rd_addr` one cycle after the address is presented. The array holds zero in every byte before the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Word address received (one-cycle pulse) |
| addr_in | input | 7 | Word address value |
| data_load | input | 1 | Data byte acknowledged (one-cycle pulse) |
| data_in | input | 8 | Data byte value |
| start_evt | input | 1 | Start condition seen on the bus |
| stop_evt | input | 1 | Stop condition seen on the bus |
| poll_req | input | 1 | Address byte awaiting an acknowledge decision |
| rd_addr | input | 7 | Array read address |
| busy | output | 1 | Commit window active |
| done | output | 1 | One-cycle pulse when the commit window ends |
| poll_ack | output | 1 | Acknowledge grant for the previous poll_req |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The assertions assume that the front end raises at most one of `addr_load`, `data_load`, `start_evt` and `stop_evt` in any cycle, and that a stop carrying data always comes while the engine is idle. The stimulus keeps to this by driving one event per task call, each held for a single cycle. Inside the commit window the assertions tolerate arbitrary overlapping events, because the engine is required to drop them. The bench uses that freedom to fire random combinations of address, data, start, stop and poll pulses throughout the busy window.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int DEF_ADDR_W    = 7;
  localparam int DEF_PAGE_W    = 2;
  localparam int DEF_DATA_W    = 8;
  localparam int DEF_WR_CYCLES = 40;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_HOLD = 2'd2
  } pce_state_e;
endpackage

// File: rtl/pce_page_buf.sv
module pce_page_buf #(
  parameter int ADDR_W = pce_pkg::DEF_ADDR_W,
  parameter int PAGE_W = pce_pkg::DEF_PAGE_W,
  parameter int DATA_W = pce_pkg::DEF_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy,
  input  logic                     last,
  input  logic                     addr_load,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     data_load,
  input  logic [DATA_W-1:0]        data_in,
  input  logic                     start_evt,
  input  logic [PAGE_W-1:0]        rd_slot,
  output logic [ADDR_W-PAGE_W-1:0] base,
  output logic [(1<<PAGE_W)-1:0]   mask,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     rd_hit
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W-1:0] ptr;
  logic [DATA_W-1:0] slots_q [PAGE_BYTES];
  logic              take_byte;

  assign take_byte = !busy && !start_evt && !addr_load && data_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      ptr  <= '0;
      base <= '0;
    end else if (busy) begin
      if (last) mask <= '0;
    end else if (start_evt) begin
      mask <= '0;
    end else if (addr_load) begin
      base <= addr_in[ADDR_W-1:PAGE_W];
      ptr  <= addr_in[PAGE_W-1:0];
      mask <= '0;
    end else if (data_load) begin
      mask[ptr] <= 1'b1;
      ptr       <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) slots_q[ptr] <= data_in;
  end

  assign rd_byte = slots_q[rd_slot];
  assign rd_hit  = mask[rd_slot];

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> ($stable(mask) && $stable(base))); // R9
  AST_START_DISCARDS: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !busy) |=> (mask == '0)); // R10
  AST_MASK_EMPTY_AFTER: assert property (@(posedge clk) disable iff (rst)
    last |=> (mask == '0)); // R4
endmodule

// File: rtl/pce_commit_ctl.sv
module pce_commit_ctl #(
  parameter int PAGE_W    = pce_pkg::DEF_PAGE_W,
  parameter int WR_CYCLES = pce_pkg::DEF_WR_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_evt,
  input  logic              poll_req,
  input  logic              has_data,
  output logic              busy,
  output logic              done,
  output logic              poll_ack,
  output logic              last,
  output logic              copy_en,
  output logic [PAGE_W-1:0] slot
);
  import pce_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  pce_state_e       st;
  logic [CNT_W-1:0] cnt;

  assign last    = (st == ST_HOLD) && (cnt == CNT_W'(WR_CYCLES - 1));
  assign copy_en = (st == ST_COPY);
  assign slot    = cnt[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      poll_ack <= 1'b0;
    end else begin
      done     <= 1'b0;
      poll_ack <= poll_req && !busy;
      case (st)
        ST_IDLE: begin
          if (stop_evt && has_data) begin
            st   <= ST_COPY;
            busy <= 1'b1;
            cnt  <= '0;
          end
        end
        ST_COPY: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PAGE_BYTES - 1)) st <= ST_HOLD;
        end
        ST_HOLD: begin
          if (last) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && has_data && !busy) |=> busy); // R5
  AST_IDLE_STOP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !has_data && !busy) |=> !busy); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

// File: rtl/pce_array.sv
module pce_array #(
  parameter int ADDR_W = pce_pkg::DEF_ADDR_W,
  parameter int DATA_W = pce_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int ADDR_W    = pce_pkg::DEF_ADDR_W,
  parameter int PAGE_W    = pce_pkg::DEF_PAGE_W,
  parameter int DATA_W    = pce_pkg::DEF_DATA_W,
  parameter int WR_CYCLES = pce_pkg::DEF_WR_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              poll_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output logic              poll_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]      base;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_byte;
  logic                  rd_hit;
  logic                  last;
  logic                  copy_en;
  logic [PAGE_W-1:0]     slot;

  pce_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .busy(busy), .last(last),
    .addr_load(addr_load), .addr_in(addr_in),
    .data_load(data_load), .data_in(data_in), .start_evt(start_evt),
    .rd_slot(slot), .base(base), .mask(mask), .rd_byte(rd_byte), .rd_hit(rd_hit)
  );

  pce_commit_ctl #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .stop_evt(stop_evt), .poll_req(poll_req),
    .has_data(|mask), .busy(busy), .done(done), .poll_ack(poll_ack),
    .last(last), .copy_en(copy_en), .slot(slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= copy_en && rd_hit;
      mem_addr  <= {base, slot};
      mem_wdata <= rd_byte;
    end
  end

  pce_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R7
  AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:PAGE_W] == base)); // R2
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !poll_ack); // R8
endmodule

// File: tb/page_commit_engine_bench.sv
`timescale 1ns/100ps
module page_commit_engine_bench;
  localparam int ADDR_W = 7, PAGE_W = 2, DATA_W = 8, WR_CYCLES = 24;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rst = 1'b1;
  logic addr_load = 0, data_load = 0, start_evt = 0, stop_evt = 0, poll_req = 0;
  logic [ADDR_W-1:0] addr_in = '0, rd_addr = '0;
  logic [DATA_W-1:0] data_in = '0;
  logic busy, done, poll_ack, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, rd_data;

  page_commit_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                       .WR_CYCLES(WR_CYCLES)) u_page_commit_engine (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .data_load(data_load), .data_in(data_in), .start_evt(start_evt),
    .stop_evt(stop_evt), .poll_req(poll_req), .rd_addr(rd_addr),
    .busy(busy), .done(done), .poll_ack(poll_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [DEPTH];

  function automatic int ones4(input logic [3:0] m);
    int c = 0;
    for (int i = 0; i < 4; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [4:0] page, input int s);
    return {page, 2'(s)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    addr_load = 0; data_load = 0; start_evt = 0; stop_evt = 0; poll_req = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; clear_in();
  endtask

  task automatic drv_addr(input logic [ADDR_W-1:0] a);
    @(negedge clk); addr_load = 1; addr_in = a; step();
  endtask
  task automatic drv_data(input logic [DATA_W-1:0] d);
    @(negedge clk); data_load = 1; data_in = d; step();
  endtask
  task automatic drv_start();
    @(negedge clk); start_evt = 1; step();
  endtask
  task automatic drv_stop();
    @(negedge clk); stop_evt = 1; step();
  endtask

  task automatic wait_commit(input bit junk, input logic [3:0] pm, input logic [4:0] page);
    int hi = 1, wes = 0;
    bit polled;
    while (1) begin
      @(negedge clk);
      polled = 0;
      if (junk) begin
        addr_load = 1'($urandom); addr_in = 7'($urandom);
        data_load = 1'($urandom); data_in = 8'($urandom);
        start_evt = 1'($urandom); stop_evt = 1'($urandom);
        poll_req = 1'($urandom); polled = poll_req;
      end
      step();
      if (mem_we) begin
        wes++;
        chk(mem_addr[6:2] == page, "R2 write page", mem_addr[6:2], page);
      end
      if (polled) chk(poll_ack == 0, "R8 poll during busy", poll_ack, 0);
      if (!busy) break;
      hi++;
      if (hi > WR_CYCLES + 8) break;
    end
    chk(hi == WR_CYCLES, "R5 busy length", hi, WR_CYCLES);
    chk(done == 1, "R6 done pulse", done, 1);
    chk(wes == ones4(pm), "R7 write count", wes, ones4(pm));
    step();
    chk(done == 0, "R6 done single", done, 0);
  endtask

  task automatic do_page(input logic [ADDR_W-1:0] a, input int n, input bit junk);
    logic [DATA_W-1:0] pb [4];
    logic [3:0] pm = '0;
    int s = int'(a[1:0]);
    drv_addr(a);
    for (int k = 0; k < n; k++) begin
      logic [DATA_W-1:0] b = 8'($urandom);
      drv_data(b);
      pb[s] = b; pm[s] = 1'b1; s = (s + 1) % 4;
    end
    drv_stop();
    chk(busy == 1, "R5 busy rises", busy, 1);
    wait_commit(junk, pm, a[6:2]);
    for (int i = 0; i < 4; i++)
      if (pm[i]) model[slot_addr(a[6:2], i)] = pb[i];
    @(negedge clk); poll_req = 1; step();
    chk(poll_ack == 1, "R8 poll after done", poll_ack, 1);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rd_addr = 7'(i);
      @(posedge clk); #1;
      chk(rd_data == model[i], tag, rd_data, model[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #1;
    chk(busy == 0, "R1 busy in reset", busy, 0);
    chk(done == 0, "R1 done in reset", done, 0);
    chk(mem_we == 0, "R1 we in reset", mem_we, 0);
    chk(poll_ack == 0, "R1 ack in reset", poll_ack, 0);
    @(negedge clk); rst = 0;
    step();
    chk(busy == 0 && poll_ack == 0, "R1 after reset", busy, 0);
    sweep("R11 initial zero");

    do_page(7'h05, 1, 0);
    sweep("R4 single byte");

    do_page(7'h4A, 6, 0);
    sweep("R3 wrap six bytes");

    drv_addr(7'h10);
    drv_stop();
    chk(busy == 0, "R10 stop without data", busy, 0);
    step();
    chk(busy == 0, "R10 stays idle", busy, 0);
    drv_addr(7'h10);
    drv_data(8'hAA);
    drv_data(8'hBB);
    drv_start();
    drv_stop();
    chk(busy == 0, "R10 start discards", busy, 0);
    drv_addr(7'h11);
    drv_data(8'hCC);
    drv_addr(7'h12);
    drv_stop();
    chk(busy == 0, "R10 address discards", busy, 0);
    sweep("R10 no commit");

    do_page(7'h33, 3, 1);
    sweep("R9 ignored while busy");

    for (int t = 0; t < 24; t++)
      do_page(7'($urandom), 1 + int'($urandom % 7), 1'($urandom));
    sweep("R4 random pages");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule